// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one per clock. A start pulse supplies the first column and takes a snapshot of the burst-length code and the ordering bit from the mode register. The block then steps through the burst. In sequential order the low column bits count up and wrap inside a block aligned to the burst length. In interleaved order each beat is the first column XORed with the beat index. Each address comes with a valid flag, and the final beat of a fixed-length burst also carries a last flag.

A full-page burst walks the whole page, wraps from the top column to column 0 and keeps going until a new start or a stop ends it. A start may arrive on any clock. It drops whatever remains of the current burst and opens a new one at its full length. A stop ends the burst on the next clock. Data movement, CAS latency, bank and row state and the data pins belong to the surrounding controller. The column width is a parameter: 8, 9 or 10 bits for the three usual organizations.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released, col_valid, last_beat and config_error are low, and col_addr reads 0 whenever col_valid is low.
- R2: A start sampled at a clock edge makes col_valid high after that edge, with col_addr equal to start_col. One further address follows per clock. The number of beats is taken from bl_code: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8.
- R3: In sequential order (interleave = 0), the column bits below the burst length count up from start_col modulo the burst length, and the bits above stay equal to start_col.
- R4: In interleaved order (interleave = 1), beat k carries start_col XOR k. For length 8 and start column 2 the order is 2,3,0,1,6,7,4,5.
- R5: last_beat is high on exactly the final beat of a 1, 2, 4 or 8 beat burst. col_valid goes low on the next clock unless a start arrives.
- R6: bl_code 111 selects a full-page burst. It steps up by one column per clock, wraps from the top column to column 0, never raises last_beat and runs until a start or a stop.
- R7: A full-page burst requested with interleave = 1 runs in sequential order, and config_error is high for that burst.
- R8: A reserved bl_code (100, 101, 110) gives a single-beat burst, and config_error is high for that burst.
- R9: A start during a burst restarts at the new column with the full programmed length. A start and a stop on the same clock act as a start.
- R10: A stop without a start drops col_valid and last_beat after that edge.
- R11: bl_code and interleave are sampled only with a start. Changing them during a burst has no effect on its addresses or length.
- R12: config_error changes only at a start and then reflects the configuration of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bl_code | input | 3 | Burst-length code from the mode register |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects sequential |
| start | input | 1 | Read or write command accepted this clock |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Burst stop |
| col_addr | output | COL_W | Current column address, 0 when idle |
| col_valid | output | 1 | col_addr carries a beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| config_error | output | 1 | Burst uses an unsupported length or ordering |

## Verification
A wrong beat counter or a wrong snapshot of the burst base shows up on col_addr on the first beat after the start or on the beat after it. A wrong length mask first shows at the block boundary, where the wrap of the low bits goes wrong and last_beat appears on the wrong beat. A full page that is wrongly stopped or wrongly flagged shows on col_valid or last_beat as soon as the count passes the top column. Because the reference model is compared on every clock, each of these faults is reported in the cycle where it first appears.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   typedef enum logic [2:0] {
      BLC_1    = 3'b000,
      BLC_2    = 3'b001,
      BLC_4    = 3'b010,
      BLC_8    = 3'b011,
      BLC_PAGE = 3'b111
   } blen_code_e;

   localparam int MIN_COL_W = 3;
   localparam int MAX_COL_W = 16;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
   import colgen_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [2:0]       bl_code,
   input  logic             interleave,
   output logic [COL_W-1:0] len_mask,
   output logic             page_mode,
   output logic             xor_order,
   output logic             cfg_bad
);
   always_comb begin
      len_mask  = '0;
      page_mode = 1'b0;
      cfg_bad   = 1'b0;
      case (blen_code_e'(bl_code))
         BLC_1:    len_mask = '0;
         BLC_2:    len_mask[0] = 1'b1;
         BLC_4:    len_mask[1:0] = 2'b11;
         BLC_8:    len_mask[2:0] = 3'b111;
         BLC_PAGE: begin
            len_mask  = '1;
            page_mode = 1'b1;
            cfg_bad   = interleave;
         end
         default:  cfg_bad = 1'b1;
      endcase
      xor_order = interleave & ~page_mode;
   end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             final_beat,
   output logic             active,
   output logic [COL_W-1:0] beat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= '0;
      end else if (start) begin
         active <= 1'b1;
         beat   <= '0;
      end else if (stop) begin
         active <= 1'b0;
         beat   <= '0;
      end else if (active) begin
         if (final_beat) begin
            active <= 1'b0;
            beat   <= '0;
         end else begin
            beat <= beat + 1'b1;
         end
      end
   end
endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen #(
   parameter int COL_W = 8
) (
   input  logic             active,
   input  logic             xor_order,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] len_mask,
   output logic [COL_W-1:0] addr
);
   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] pick;

   assign sum = base + beat;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      logic seq_bit;
      assign seq_bit = len_mask[i] ? sum[i] : base[i];
      assign pick[i] = xor_order ? (base[i] ^ beat[i]) : seq_bit;
   end

   assign addr = active ? pick : '0;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import colgen_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bl_code,
   input  logic             interleave,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             stop,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic             last_beat,
   output logic             config_error
);
   if (COL_W < MIN_COL_W || COL_W > MAX_COL_W) begin : g_bad_width
      $error("sdram_burst_colgen: COL_W out of range");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_page, dec_xor, dec_bad;
   logic [COL_W-1:0] mask_q, base_q, beat;
   logic             page_q, xor_q, err_q, active, final_beat;

   colgen_mode_dec #(.COL_W(COL_W)) u_dec (
      .bl_code    (bl_code),
      .interleave (interleave),
      .len_mask   (dec_mask),
      .page_mode  (dec_page),
      .xor_order  (dec_xor),
      .cfg_bad    (dec_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         base_q <= '0;
         page_q <= 1'b0;
         xor_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (start) begin
         mask_q <= dec_mask;
         base_q <= start_col;
         page_q <= dec_page;
         xor_q  <= dec_xor;
         err_q  <= dec_bad;
      end
   end

   assign final_beat = active & ~page_q & (beat == mask_q);

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .stop       (stop),
      .final_beat (final_beat),
      .active     (active),
      .beat       (beat)
   );

   colgen_addr_gen #(.COL_W(COL_W)) u_addr (
      .active    (active),
      .xor_order (xor_q),
      .base      (base_q),
      .beat      (beat),
      .len_mask  (mask_q),
      .addr      (col_addr)
   );

   assign col_valid    = active;
   assign last_beat    = final_beat;
   assign config_error = err_q;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       bl_code,
   input logic             interleave,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic             stop,
   input logic [COL_W-1:0] col_addr,
   input logic             col_valid,
   input logic             last_beat,
   input logic             config_error
);
   // R1
   idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_valid |-> col_addr == '0);
   // R2
   start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> col_valid && col_addr == $past(start_col));
   // R5
   last_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> col_valid);
   // R5
   last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat && !start |=> !col_valid);
   // R10
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop && !start |=> !col_valid && !last_beat);
   // R6
   page_never_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && bl_code == 3'b111 |=> !last_beat);
   // R12
   err_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(config_error));
   // R2
   idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_valid && !start |=> !col_valid);
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_sdram_burst_colgen.sv
`timescale 1ns/1ps
module sim_sdram_burst_colgen;
   localparam int W    = 8;
   localparam int PAGE = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   bl_code = 3'b000;
   logic         interleave = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] start_col = '0;
   logic         stop = 1'b0;
   logic [W-1:0] col_addr;
   logic         col_valid, last_beat, config_error;

   int checks = 0;
   int errors = 0;
   string req = "R1";

   // model state
   int m_act = 0, m_cnt = 0, m_base = 0, m_len = 1, m_full = 0, m_xor = 0, m_err = 0;

   always #10 clk = ~clk;

   sdram_burst_colgen #(.COL_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bl_code(bl_code), .interleave(interleave),
      .start(start), .start_col(start_col), .stop(stop),
      .col_addr(col_addr), .col_valid(col_valid), .last_beat(last_beat),
      .config_error(config_error)
   );

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
      end
   endtask

   function automatic int exp_addr();
      int lo;
      if (!m_act) return 0;
      if (m_xor) return (m_base ^ m_cnt) % PAGE;
      lo = m_len - 1;
      return ((m_base & ~lo) | ((m_base + m_cnt) & lo)) % PAGE;
   endfunction

   task automatic model_edge(input logic s, input logic p, input int col,
                             input logic [2:0] code, input logic il);
      if (s) begin
         m_act = 1; m_cnt = 0; m_base = col; m_full = 0; m_err = 0;
         case (code)
            3'b000: m_len = 1;
            3'b001: m_len = 2;
            3'b010: m_len = 4;
            3'b011: m_len = 8;
            3'b111: begin m_len = PAGE; m_full = 1; end
            default: begin m_len = 1; m_err = 1; end
         endcase
         m_xor = il && !m_full;
         if (m_full && il) m_err = 1;
      end else if (p) begin
         m_act = 0;
      end else if (m_act) begin
         if (!m_full && m_cnt == m_len - 1) m_act = 0;
         else m_cnt = (m_cnt + 1) % PAGE;
      end
   endtask

   task automatic compare();
      chk({req, " valid"}, int'(col_valid), m_act);
      chk({req, " addr"},  int'(col_addr), exp_addr());
      chk({req, " last"},  int'(last_beat), (m_act && !m_full && m_cnt == m_len - 1) ? 1 : 0);
      chk({req, " cfgerr"}, int'(config_error), m_err);
   endtask

   // inputs are set before the call (after a negedge)
   task automatic tick();
      @(posedge clk);
      model_edge(start, stop, int'(start_col), bl_code, interleave);
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      compare();
   endtask

   task automatic go(input logic [2:0] code, input logic il, input int col);
      bl_code = code; interleave = il; start_col = col[W-1:0]; start = 1'b1;
      tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ilv[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
      // R1 reset state
      req = "R1";
      repeat (3) @(negedge clk);
      compare();
      rst_n = 1'b1;
      idle(2);

      // R2 / R3 / R5 sequential lengths
      req = "R2_R3_R5";
      go(3'b000, 1'b0, 37); idle(2);
      go(3'b001, 1'b0, 37); idle(3);
      go(3'b010, 1'b0, 6);  idle(5);
      go(3'b011, 1'b0, 45); idle(9);

      // R4 interleaved, literal order check
      req = "R4";
      go(3'b011, 1'b1, 2);
      chk("R4 order", int'(col_addr), ilv[0]);
      for (int i = 1; i < 8; i++) begin
         tick();
         chk("R4 order", int'(col_addr), ilv[i]);
      end
      tick();
      go(3'b010, 1'b1, 7); idle(5);
      go(3'b001, 1'b1, 9); idle(3);

      // R6 full page wrap across top column
      req = "R6";
      go(3'b111, 1'b0, 252); idle(12);
      stop = 1'b1; tick();
      req = "R10";
      idle(2);

      // R7 full page with interleave
      req = "R7";
      go(3'b111, 1'b1, 250); idle(10);
      req = "R12";
      bl_code = 3'b000; interleave = 1'b0; idle(2);
      stop = 1'b1; tick(); idle(2);

      // R8 reserved codes
      req = "R8";
      go(3'b100, 1'b0, 17); idle(2);
      go(3'b110, 1'b1, 18); idle(2);

      // R9 restart mid-burst and start beats stop
      req = "R9";
      go(3'b011, 1'b0, 16); idle(3);
      go(3'b011, 1'b0, 100); idle(2);
      stop = 1'b1; bl_code = 3'b010; interleave = 1'b1; start_col = 8'd33; start = 1'b1;
      tick(); idle(5);

      // R10 stop mid fixed burst
      req = "R10";
      go(3'b011, 1'b1, 64); idle(2);
      stop = 1'b1; tick(); idle(2);

      // R11 config change during burst ignored
      req = "R11";
      go(3'b011, 1'b0, 5);
      bl_code = 3'b000; interleave = 1'b1; idle(9);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule